// File: doc/BRIEF.md
# Hypercube Dimension-Order Router

Per-node next-hop unit for a binary hypercube with at most ten dimensions. Each node has an address, and two nodes are linked when their addresses differ in exactly one bit, so each bit position names one outgoing link. A message header brings a destination address and a byte length. The unit XORs the destination with the node's own address to get the set of dimensions still to cross. It then picks the lowest dimension in that set, so low dimensions are always crossed before high ones. When no dimension remains, the packet is steered to local delivery.

The same header is used on the source node and on every intermediate node. The unit cuts the message into packets of a fixed maximum byte count, given by a parameter. It presents one routing decision per packet on a valid/ready output. Every packet of a message carries the same route, and the last packet carries the remainder. If the destination has a bit set above the configured dimension count, the header is flagged as an addressing error rather than routed.

Top module: `hypercube_router`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: For an in-range destination that differs from node_id, out_local=0, out_err=0, and out_chan is the index of the least significant 1 in (node_id XOR in_dest) over bits 0..DIMS-1.
- R3: When in_dest equals node_id, out_local=1, out_err=0 and out_chan=0.
- R4: When any bit of in_dest at index DIMS or above is 1, out_err=1, out_local=0 and out_chan=0. out_local and out_err are never both 1.
- R5: A message of L bytes produces ceil(L/PKT_BYTES) packets, with a minimum of one. Every packet except the last has out_len=PKT_BYTES and out_last=0. The last packet has out_len=L minus the bytes already sent, and out_last=1. A zero-length message yields one packet with out_len=0.
- R6: While out_valid=1 and out_ready=0, every output field holds its value.
- R7: While a message is being emitted, in_ready is 0 and in_valid/in_dest/in_len have no effect on the packets of that message or on what follows.
- R8: A header accepted on a clock edge (in_valid and in_ready both 1) makes out_valid 1 from the next cycle, with its first packet.
- R9: out_chan, out_local and out_err stay the same across all packets of one message.
- R10: A routed packet (out_local=0, out_err=0) has out_chan < DIMS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 10 | Address of this node |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Unit can accept a header |
| in_dest | input | 10 | Destination node address |
| in_len | input | LEN_W | Message length in bytes |
| out_valid | output | 1 | A packet decision is presented |
| out_ready | input | 1 | Downstream takes the decision |
| out_chan | output | 4 | Dimension (link) to cross next |
| out_local | output | 1 | Deliver to this node |
| out_err | output | 1 | Destination out of range |
| out_len | output | LEN_W | Byte count of this packet |
| out_last | output | 1 | Final packet of the message |

## Verification
The assertions check on every cycle that a stalled output holds still, that the route stays fixed inside a message, that non-final packets are full sized, that a routed channel is below the dimension count, that local and error are never raised together, and that acceptance and reset act on out_valid with the right timing. Only the bench scenarios can show that the chosen channel is the lowest differing dimension and that delivery and error are decided correctly for each address pair. The bench also shows the exact packet count and remainder for each length, and that a header offered while the unit is busy is dropped without disturbing the message in flight.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
    localparam int ADDR_W   = 10;
    localparam int MAX_DIMS = 10;
    localparam int CH_W     = 4;

    typedef logic [ADDR_W-1:0] node_addr_t;
    typedef logic [CH_W-1:0]   chan_t;

    typedef struct packed {
        chan_t chan;
        logic  local_hit;
        logic  bad_addr;
    } route_t;

    // index of the least significant set bit, 0 when none
    function automatic chan_t lowest_one(input node_addr_t w);
        chan_t r;
        r = '0;
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            if (w[i]) r = chan_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/hcr_route_calc.sv
module hcr_route_calc
    import hcr_pkg::*;
#(
    parameter int DIMS = 10
) (
    input  node_addr_t self_addr,
    input  node_addr_t dest_addr,
    output route_t     route
);
    localparam node_addr_t LOW_MASK = node_addr_t'((1 << DIMS) - 1);

    logic       upper_set;
    node_addr_t low_diff;

    generate
        if (DIMS < ADDR_W) begin : g_upper
            assign upper_set = |dest_addr[ADDR_W-1:DIMS];
        end else begin : g_full
            assign upper_set = 1'b0;
        end
    endgenerate

    assign low_diff = (self_addr ^ dest_addr) & LOW_MASK;

    always_comb begin
        route.bad_addr  = upper_set;
        route.local_hit = !upper_set && (low_diff == '0);
        route.chan      = upper_set ? chan_t'(0) : lowest_one(low_diff);
    end
endmodule

// File: rtl/hcr_pkt_sizer.sv
module hcr_pkt_sizer #(
    parameter int LEN_W     = 16,
    parameter int PKT_BYTES = 512
) (
    input  logic [LEN_W-1:0] remaining,
    output logic [LEN_W-1:0] pkt_len,
    output logic             pkt_last
);
    localparam logic [LEN_W-1:0] PKT = LEN_W'(PKT_BYTES);

    always_comb begin
        pkt_last = (remaining <= PKT);
        pkt_len  = pkt_last ? remaining : PKT;
    end
endmodule

// File: rtl/hypercube_router.sv
module hypercube_router
    import hcr_pkg::*;
#(
    parameter int DIMS      = 10,
    parameter int LEN_W     = 16,
    parameter int PKT_BYTES = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [9:0]       node_id,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [9:0]       in_dest,
    input  logic [LEN_W-1:0] in_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [3:0]       out_chan,
    output logic             out_local,
    output logic             out_err,
    output logic [LEN_W-1:0] out_len,
    output logic             out_last
);
    route_t           route_d;
    route_t           route_q;
    logic             valid_q;
    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] cur_len;
    logic             cur_last;
    logic             take_hdr;
    logic             take_pkt;

    hcr_route_calc #(.DIMS(DIMS)) u_route (
        .self_addr (node_id),
        .dest_addr (in_dest),
        .route     (route_d)
    );

    hcr_pkt_sizer #(.LEN_W(LEN_W), .PKT_BYTES(PKT_BYTES)) u_size (
        .remaining (rem_q),
        .pkt_len   (cur_len),
        .pkt_last  (cur_last)
    );

    assign in_ready = !valid_q;
    assign take_hdr = in_valid && in_ready;
    assign take_pkt = valid_q && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rem_q   <= '0;
            route_q <= '0;
        end else if (take_hdr) begin
            valid_q <= 1'b1;
            rem_q   <= in_len;
            route_q <= route_d;
        end else if (take_pkt) begin
            if (cur_last) valid_q <= 1'b0;
            else          rem_q   <= rem_q - cur_len;
        end
    end

    assign out_valid = valid_q;
    assign out_chan  = route_q.chan;
    assign out_local = route_q.local_hit;
    assign out_err   = route_q.bad_addr;
    assign out_len   = cur_len;
    assign out_last  = cur_last;
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker #(
    parameter int DIMS      = 10,
    parameter int LEN_W     = 16,
    parameter int PKT_BYTES = 512
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [3:0]       out_chan,
    input logic             out_local,
    input logic             out_err,
    input logic [LEN_W-1:0] out_len,
    input logic             out_last
);
    // R1
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);

    // R8
    a_r8_accept_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    // R6
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_chan) && $stable(out_local)
            && $stable(out_err) && $stable(out_len) && $stable(out_last));

    // R9
    a_r9_route_kept: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !out_last |=> out_valid && $stable(out_chan)
            && $stable(out_local) && $stable(out_err));

    // R5
    a_r5_full_body: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_last |-> out_len == LEN_W'(PKT_BYTES));

    a_r5_tail_bound: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last |-> out_len <= LEN_W'(PKT_BYTES));

    // R10
    a_r10_chan_range: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_local && !out_err |-> int'(out_chan) < DIMS);

    // R4
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_local && out_err));
endmodule

bind hypercube_router hcr_checker #(
    .DIMS(DIMS), .LEN_W(LEN_W), .PKT_BYTES(PKT_BYTES)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .out_local(out_local), .out_err(out_err), .out_len(out_len), .out_last(out_last)
);

// File: tb/tb_hypercube_router.sv
module tb_hypercube_router;
    localparam int CLK_PERIOD = 10;
    localparam int DIMS  = 4;
    localparam int LEN_W = 8;
    localparam int PKT   = 8;
    localparam int WATCHDOG = 200000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [9:0]       node_id = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [9:0]       in_dest = '0;
    logic [LEN_W-1:0] in_len = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [3:0]       out_chan;
    logic             out_local;
    logic             out_err;
    logic [LEN_W-1:0] out_len;
    logic             out_last;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    hypercube_router #(.DIMS(DIMS), .LEN_W(LEN_W), .PKT_BYTES(PKT)) dut (
        .clk(clk), .rst(rst), .node_id(node_id), .in_valid(in_valid), .in_ready(in_ready),
        .in_dest(in_dest), .in_len(in_len), .out_valid(out_valid), .out_ready(out_ready),
        .out_chan(out_chan), .out_local(out_local), .out_err(out_err),
        .out_len(out_len), .out_last(out_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_chan(input int a, input int b);
        int d = (a ^ b) & ((1 << DIMS) - 1);
        for (int i = 0; i < DIMS; i++) if (d[i]) return i;
        return 0;
    endfunction

    task automatic run_msg(input int node, input int dest, input int len, input bit stall_en);
        int  e_err, e_loc, e_ch, rem, sz, lst, pk;
        e_err = ((dest >> DIMS) != 0) ? 1 : 0;
        e_loc = (!e_err && (((node ^ dest) & ((1 << DIMS) - 1)) == 0)) ? 1 : 0;
        e_ch  = (e_err || e_loc) ? 0 : exp_chan(node, dest);
        @(negedge clk);
        node_id  = 10'(node);
        in_dest  = 10'(dest);
        in_len   = LEN_W'(len);
        in_valid = 1'b1;
        @(negedge clk);
        // R8: first packet one cycle after accept
        chk(out_valid == 1'b1, "R8 out_valid after accept", int'(out_valid), 1);
        // R7: offer a different header while busy
        chk(in_ready == 1'b0, "R7 in_ready while busy", int'(in_ready), 0);
        in_dest = 10'(dest ^ 10'h2A5);
        in_len  = LEN_W'(len + 13);
        rem = len;
        pk  = 0;
        do begin
            lst = (rem <= PKT) ? 1 : 0;
            sz  = lst ? rem : PKT;
            chk(out_valid == 1'b1, "R7 packet present", int'(out_valid), 1);
            chk(int'(out_err) == e_err, "R4 error flag", int'(out_err), e_err);
            chk(int'(out_local) == e_loc, "R3 local flag", int'(out_local), e_loc);
            chk(int'(out_chan) == e_ch, "R2 channel (R9 across packets)", int'(out_chan), e_ch);
            chk(int'(out_len) == sz, "R5 packet length", int'(out_len), sz);
            chk(int'(out_last) == lst, "R5 last flag", int'(out_last), lst);
            if (stall_en && ((pk + node) % 3 == 0)) begin
                out_ready = 1'b0;
                @(negedge clk);
                chk(out_valid && int'(out_chan) == e_ch && int'(out_len) == sz
                    && int'(out_last) == lst && int'(out_local) == e_loc,
                    "R6 hold under stall", int'(out_len), sz);
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            rem -= sz;
            pk++;
        end while (lst == 0);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R7 idle after last packet", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R7 ready after message", int'(in_ready), 1);
        chk(pk == ((len == 0) ? 1 : (len + PKT - 1) / PKT), "R5 packet count", pk,
            (len == 0) ? 1 : (len + PKT - 1) / PKT);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);

        // R2/R3/R10: every in-range address pair
        for (int n = 0; n < (1 << DIMS); n++) begin
            for (int d = 0; d < (1 << DIMS); d++) begin
                run_msg(n, d, (n * 7 + d * 3) % 26, 1'b1);
            end
        end

        // R5 boundaries: zero, exact multiples, one over, longest
        run_msg(3, 12, 0, 1'b0);
        run_msg(3, 12, PKT, 1'b0);
        run_msg(3, 12, 2 * PKT, 1'b1);
        run_msg(3, 12, PKT + 1, 1'b0);
        run_msg(9, 9, 255, 1'b1);

        // R4: destinations with upper bits set
        for (int d = 16; d < 1024; d += 37) begin
            run_msg(5, d, d % 19, 1'b1);
        end
        run_msg(0, 512, 4, 1'b0);
        run_msg(15, 1023, 9, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule